// File: doc/BRIEF.md
# Parity-Checked Bidirectional Bus Transceiver

This block moves a byte between an A side and a B side in either direction and carries a parity bit alongside it. One level on the direction input sends A data to B. The other level sends B data to A. The block is a purely combinational path. Each pad that would be three-state in silicon is modelled here as three separate signals: an input value, an output value and a drive enable.

The parity line follows the data flow.
- **Transmit:** the block drives the parity line with a bit computed from the A byte. The bit makes the nine-bit group meet the chosen sense, odd or even.
- **Receive:** the parity line is an input. The block counts the ones in the B byte together with that input. An active-low error flag reports a group that does not meet the sense.
- **Disabled:** an active-low enable turns off every driver when it is released.

The top groups a parameterized number of identical sections. Each section has its own controls. The default build is two byte sections.

Top module: `par_xcvr`

## Requirements
- R1: With the enable low and the direction bit high (transmit), the B drive enable is 1, the A drive enable is 0, and the B output equals the A input bit for bit with no inversion.
- R2: With the enable low and the direction bit low (receive), the A drive enable is 1, the B drive enable is 0, and the A output equals the B input bit for bit with no inversion.
- R3: With the enable high, the A, B and parity drive enables of that section are all 0, whatever the other inputs are.
- R4: In enabled transmit, the parity output makes the count of ones over the A byte plus parity odd when the sense bit is 1 and even when it is 0. For example, with even sense and five ones, the parity output is 1.
- R5: In enabled receive, the error flag is 0 exactly when the count of ones over the B byte plus the parity input disagrees with the sense. For example, with odd sense, parity input 1 and three ones, the flag is 0.
- R6: In transmit, or while the enable is high, the error flag is 1.
- R7: The parity drive enable is 1 only in enabled transmit. In receive the parity line is not driven.
- R8: Section k uses data bits [8k+7:8k] and control bit k only. Changing the inputs of one section leaves the outputs of the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dirTx | input | 2 | Per-section direction, 1 = A to B |
| oeN | input | 2 | Per-section active-low enable |
| oddSel | input | 2 | Per-section parity sense, 1 = odd |
| aIn | input | 16 | A-side pad input values |
| aOut | output | 16 | A-side pad output values |
| aOe | output | 2 | Per-section A-side drive enable |
| bIn | input | 16 | B-side pad input values |
| bOut | output | 16 | B-side pad output values |
| bOe | output | 2 | Per-section B-side drive enable |
| parIn | input | 2 | Per-section parity pad input |
| parOut | output | 2 | Per-section parity pad output |
| parOe | output | 2 | Per-section parity drive enable |
| errN | output | 2 | Per-section active-low parity error |

## Verification
The bench builds the block with its defaults: two sections of eight bits each. This lets section 0 be swept over every byte value, both senses, both parity input levels, both directions and both enable levels. Section 1 receives random inputs in the same cycles, so any cross-section leakage surfaces as a mismatch. Directed cases cover the five-ones even-sense transmit example, the three-ones odd-sense receive example, and all-zero and all-one bytes.

// File: rtl/par_xcvr_pkg.sv
package par_xcvr_pkg;
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic drivePar;
    logic checkRx;
    logic oddSense;
  } ctrlStrobes_t;
endpackage

// File: rtl/par_xcvr_ctrl.sv
module par_xcvr_ctrl
  import par_xcvr_pkg::*;
(
  input  logic         dirTx,
  input  logic         oeN,
  input  logic         oddSel,
  output ctrlStrobes_t strobes
);
  logic enabled;

  always_comb begin
    enabled          = ~oeN;
    strobes.driveB   = enabled & dirTx;
    strobes.driveA   = enabled & ~dirTx;
    strobes.drivePar = enabled & dirTx;
    strobes.checkRx  = enabled & ~dirTx;
    strobes.oddSense = oddSel;
  end

  always_comb begin
    AST_ONE_SIDE: assert (!(strobes.driveA && strobes.driveB)); // R1
  end
endmodule

// File: rtl/par_xcvr_datapath.sv
module par_xcvr_datapath
  import par_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         parIn,
  output logic [W-1:0] aOut,
  output logic         aOe,
  output logic [W-1:0] bOut,
  output logic         bOe,
  output logic         parOut,
  output logic         parOe,
  output logic         errN
);
  logic aOnesOdd;
  logic rxGroupOdd;

  always_comb begin
    aOut       = bIn;
    bOut       = aIn;
    aOe        = strobes.driveA;
    bOe        = strobes.driveB;
    aOnesOdd   = ^aIn;
    parOut     = aOnesOdd ^ strobes.oddSense;
    parOe      = strobes.drivePar;
    rxGroupOdd = (^bIn) ^ parIn;
    errN       = strobes.checkRx ? (rxGroupOdd == strobes.oddSense) : 1'b1;
  end

  always_comb begin
    if (parOe)
      AST_TX_PARITY: assert (($countones({bOut, parOut}) % 2 == 1) == strobes.oddSense); // R4
  end
endmodule

// File: rtl/par_xcvr_section.sv
module par_xcvr_section
  import par_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         dirTx,
  input  logic         oeN,
  input  logic         oddSel,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic         aOe,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic         bOe,
  input  logic         parIn,
  output logic         parOut,
  output logic         parOe,
  output logic         errN
);
  ctrlStrobes_t strobes;

  par_xcvr_ctrl i_ctrl (
    .dirTx(dirTx), .oeN(oeN), .oddSel(oddSel), .strobes(strobes)
  );

  par_xcvr_datapath #(.W(W)) i_dp (
    .strobes(strobes), .aIn(aIn), .bIn(bIn), .parIn(parIn),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe),
    .parOut(parOut), .parOe(parOe), .errN(errN)
  );

  always_comb begin
    if (oeN)
      AST_DISABLED_QUIET: assert (!aOe && !bOe && !parOe); // R3
    if (!oeN && !dirTx)
      AST_RX_CHECK: assert (errN == (($countones({bIn, parIn}) % 2 == 1) == oddSel)); // R5
    if (oeN || dirTx)
      AST_IDLE_NO_ERR: assert (errN); // R6
    if (parOe)
      AST_PAR_ONLY_TX: assert (dirTx && !oeN); // R7
    if (bOe)
      AST_TX_PASS: assert (bOut == aIn); // R1
    if (aOe)
      AST_RX_PASS: assert (aOut == bIn); // R2
  end
endmodule

// File: rtl/par_xcvr.sv
module par_xcvr #(
  parameter int NSEC = 2,
  parameter int W    = 8,
  localparam int TOTW = NSEC * W
) (
  input  logic [NSEC-1:0] dirTx,
  input  logic [NSEC-1:0] oeN,
  input  logic [NSEC-1:0] oddSel,
  input  logic [TOTW-1:0] aIn,
  output logic [TOTW-1:0] aOut,
  output logic [NSEC-1:0] aOe,
  input  logic [TOTW-1:0] bIn,
  output logic [TOTW-1:0] bOut,
  output logic [NSEC-1:0] bOe,
  input  logic [NSEC-1:0] parIn,
  output logic [NSEC-1:0] parOut,
  output logic [NSEC-1:0] parOe,
  output logic [NSEC-1:0] errN
);
  for (genvar k = 0; k < NSEC; k++) begin : g_sec // R8
    par_xcvr_section #(.W(W)) i_sec (
      .dirTx(dirTx[k]), .oeN(oeN[k]), .oddSel(oddSel[k]),
      .aIn(aIn[k*W +: W]), .aOut(aOut[k*W +: W]), .aOe(aOe[k]),
      .bIn(bIn[k*W +: W]), .bOut(bOut[k*W +: W]), .bOe(bOe[k]),
      .parIn(parIn[k]), .parOut(parOut[k]), .parOe(parOe[k]),
      .errN(errN[k])
    );
  end
endmodule

// File: tb/test_par_xcvr.sv
module test_par_xcvr;
  localparam int NSEC = 2;
  localparam int W    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NSEC-1:0]   dirTx, oeN, oddSel, parIn;
  logic [NSEC*W-1:0] aIn, bIn, aOut, bOut;
  logic [NSEC-1:0]   aOe, bOe, parOut, parOe, errN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  par_xcvr #(.NSEC(NSEC), .W(W)) i_par_xcvr (
    .dirTx(dirTx), .oeN(oeN), .oddSel(oddSel),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .parIn(parIn), .parOut(parOut), .parOe(parOe), .errN(errN)
  );

  function automatic int onesOf(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic expTxPar(input logic [W-1:0] a, input logic odd);
    // parity chosen so (ones(a) + par) is odd when odd==1, even otherwise
    logic aOdd = (onesOf(a) % 2) == 1;
    return odd ? !aOdd : aOdd;
  endfunction

  function automatic logic expErrN(input logic tx, input logic dis,
                                   input logic [W-1:0] b, input logic p,
                                   input logic odd);
    int tot;
    if (tx || dis) return 1'b1;
    tot = onesOf(b) + int'(p);
    return ((tot % 2) == 1) == odd;
  endfunction

  task automatic check1(input string tag, input int k, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sec%0d %s actual=%h expected=%h", tag, k, what, act, exp);
    end
  endtask

  task automatic checkSection(input int k);
    logic tx  = dirTx[k];
    logic dis = oeN[k];
    logic [W-1:0] a = aIn[k*W +: W];
    logic [W-1:0] b = bIn[k*W +: W];
    check1(dis ? "R3" : (tx ? "R1" : "R2"), k, "aOe", W'(aOe[k]), W'(!dis && !tx));
    check1(dis ? "R3" : (tx ? "R1" : "R2"), k, "bOe", W'(bOe[k]), W'(!dis && tx));
    check1("R7", k, "parOe", W'(parOe[k]), W'(!dis && tx));
    if (!dis && tx) begin
      check1("R1", k, "bOut", bOut[k*W +: W], a);
      check1("R4", k, "parOut", W'(parOut[k]), W'(expTxPar(a, oddSel[k])));
    end
    if (!dis && !tx) check1("R2", k, "aOut", aOut[k*W +: W], b);
    check1((tx || dis) ? "R6" : "R5", k, "errN", W'(errN[k]),
           W'(expErrN(tx, dis, b, parIn[k], oddSel[k])));
  endtask

  task automatic applyAndCheck();
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NSEC; k++) checkSection(k);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [W-1:0] saveOut;
    void'($urandom(32'h5eed_1234));
    dirTx = '0; oeN = '1; oddSel = '0; parIn = '0; aIn = '0; bIn = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R3: idle state with all sections disabled
    applyAndCheck();

    // R4 directed: even sense, five ones on A -> parity 1
    oeN = 2'b00; dirTx = 2'b11; oddSel = 2'b00; aIn = {8'h00, 8'b0001_1111};
    applyAndCheck();
    check1("R4", 0, "parOut five ones even", W'(parOut[0]), W'(1'b1));

    // R5 directed: odd sense, parity in 1, three ones on B -> errN 0
    dirTx = 2'b00; oddSel = 2'b11; parIn = 2'b11; bIn = {8'hFF, 8'b0000_0111};
    applyAndCheck();
    check1("R5", 0, "errN three ones odd", W'(errN[0]), W'(1'b0));

    // R8 directed: change section 1 only, section 0 outputs unchanged
    dirTx = 2'b01; aIn = {8'h3C, 8'hA5};
    applyAndCheck();
    saveOut = bOut[7:0];
    aIn[15:8] = 8'hC3; dirTx[1] = 1'b1; oeN[1] = 1'b1; oddSel[1] = 1'b0;
    applyAndCheck();
    check1("R8", 0, "bOut after sec1 change", bOut[7:0], saveOut);

    // Exhaustive sweep of section 0, random section 1
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 16; m++) begin
        aIn[7:0]  = 8'(v);
        bIn[7:0]  = 8'(v ^ 8'h5A);
        oddSel[0] = m[0];
        parIn[0]  = m[1];
        dirTx[0]  = m[2];
        oeN[0]    = m[3];
        aIn[15:8] = 8'($urandom);
        bIn[15:8] = 8'($urandom);
        dirTx[1]  = 1'($urandom);
        oeN[1]    = 1'($urandom);
        oddSel[1] = 1'($urandom);
        parIn[1]  = 1'($urandom);
        applyAndCheck();
      end
    end
    done = 1;
    finishRun();
  end
endmodule